// File: doc/BRIEF.md
# Windowed Oversampling Serial Receiver

This block receives asynchronous frames of programmable length on one idle-high serial line. A compare-based counter derives the bit period from the 100 MHz system clock, so the bit rate equals 100e6 divided by the programmed compare value. Each bit period is split into 16 equal sub-slots. Only samples that fall inside a programmable inclusive slot window take part in the decision for a bit. A bit is accepted cleanly only when every sample in that window agrees. Otherwise a sticky sampling-error flag is raised, and the bit takes the majority level.

A falling edge on the line starts a frame and realigns the bit counter to that edge. Accepted bits shift into a 16-bit hold value from the top, least significant bit first. When the programmed bit count is reached, the hold value is published and a ready flag is set. If a frame completes while ready is still set, an overflow flag is also raised. An optional 3-tap majority filter can clean the line before sampling. Software reaches the block through a small write port with three addresses: configuration, flag clear and counter clear. Hold data, flags, counter value, bit-clock level and synchronized line level appear as outputs.

Top module: `winsamp_rx`

## Requirements
- R1: After synchronous reset, the hold value, ready, overflow and sampling-error outputs are 0, and the counter output is 0.
- R2: While the enable bit is 0 or the compare value is 0, the counter stays at 0 and no frame is received: ready stays 0 even when a full frame is driven on the line.
- R3: While active and idle, the counter counts 0 up to compare−1 and then wraps to 0. A write to address 2 sets it to 0 at that clock edge. The bit-clock output is 1 while the sub-slot index floor(16·count/compare) is below 8, and 0 otherwise.
- R4: A falling edge starts a frame. Bits are shifted in from bit 15 downward, LSB first, so after N bits the first bit sits at position 16−N. Lower positions are 0, and a bit-count field of 0 means 16 bits.
- R5: Ready becomes 1 only at the end of the last bit period of a frame, and not earlier. It stays 1 until it is cleared.
- R6: If the samples inside the inclusive window [first, last] of a bit do not all agree, the sampling-error flag is set and stays set. The bit takes the majority level of those samples.
- R7: Samples outside the slot window have no effect on the bit value or on the sampling-error flag.
- R8: If a frame completes while ready is 1, the overflow flag is set and the hold value is replaced by the new frame. If ready is 0 when the frame completes, overflow stays 0.
- R9: A write to address 1 clears ready, overflow and sampling error at that edge, and leaves the hold value unchanged.
- R10: With the filter bit set, a one-cycle pulse on the line is removed before sampling and causes no sampling error.
- R11: The configuration at address 0 is laid out as follows: compare value in bits [15:0], enable in bit 16, filter in bit 17, bit count in [21:18], first slot in [25:22] and last slot in [29:26]. The raw-line output shows the line after a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| rxd_in | input | 1 | Serial input line, idle high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 config, 1 flag clear, 2 counter clear |
| wr_data | input | 30 | Write data (config layout in R11) |
| rx_hold | output | 16 | Last completed frame |
| rx_ready | output | 1 | Frame available |
| rx_ovf | output | 1 | Frame completed while ready was set |
| rx_splerr | output | 1 | Window samples disagreed in some bit |
| st_cnt | output | 16 | Bit counter value |
| st_bclk | output | 1 | Bit-clock level (first half of period) |
| st_raw | output | 1 | Synchronized line level |

## Verification
The ready, overflow and hold results are due at the clock edge that closes the final bit period. That edge comes a fixed synchronizer and filter delay after the bench drives the end of the stop bit, so the bench samples half a bit period after the frame ends and checks at the middle of the last bit that ready is still low. The flag clear and counter clear take effect at the edge that latches the write, and are checked at the falling clock edge that follows. Counter and bit-clock values are then checked a known number of edges later. Glitches are placed at fixed offsets inside a bit, either well inside or well outside the slot window, so the pipeline delay cannot move them across a window edge.

// File: rtl/winsamp_pkg.sv
package winsamp_pkg;
  typedef enum logic {ST_HUNT, ST_RECV} rx_st_e;

  localparam int ADR_CFG    = 0;
  localparam int ADR_RXCLR  = 1;
  localparam int ADR_CNTCLR = 2;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction
endpackage

// File: rtl/winsamp_regs.sv
module winsamp_regs #(
  parameter int CNT_W     = 16,
  parameter int NB_W      = 4,
  parameter int SLOT_BITS = 4,
  parameter int ADDR_W    = 2,
  parameter int NB_RST    = 11,
  parameter int FIRST_RST = 5,
  parameter int LAST_RST  = 10
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [CNT_W+NB_W+2*SLOT_BITS+1:0] wr_data,
  output logic [CNT_W-1:0]                  rate,
  output logic                              en,
  output logic                              filt,
  output logic [NB_W-1:0]                   nbits,
  output logic [SLOT_BITS-1:0]              first,
  output logic [SLOT_BITS-1:0]              last,
  output logic                              clr_flags,
  output logic                              clr_cnt
);
  import winsamp_pkg::*;
  localparam int EN_B    = CNT_W;
  localparam int FILT_B  = CNT_W + 1;
  localparam int NB_LSB  = CNT_W + 2;
  localparam int FST_LSB = NB_LSB + NB_W;
  localparam int LST_LSB = FST_LSB + SLOT_BITS;

  logic cfg_wr;
  assign cfg_wr    = wr_en && (wr_addr == ADDR_W'(ADR_CFG));
  assign clr_flags = wr_en && (wr_addr == ADDR_W'(ADR_RXCLR));
  assign clr_cnt   = wr_en && (wr_addr == ADDR_W'(ADR_CNTCLR));

  always_ff @(posedge clk) begin
    if (rst) begin
      rate  <= '0;
      en    <= 1'b0;
      filt  <= 1'b0;
      nbits <= NB_W'(NB_RST);
      first <= SLOT_BITS'(FIRST_RST);
      last  <= SLOT_BITS'(LAST_RST);
    end else if (cfg_wr) begin
      rate  <= wr_data[CNT_W-1:0];
      en    <= wr_data[EN_B];
      filt  <= wr_data[FILT_B];
      nbits <= wr_data[NB_LSB +: NB_W];
      first <= wr_data[FST_LSB +: SLOT_BITS];
      last  <= wr_data[LST_LSB +: SLOT_BITS];
    end
  end
endmodule

// File: rtl/winsamp_front.sv
module winsamp_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxd,
  input  logic filt,
  output logic raw,
  output logic line,
  output logic fall
);
  import winsamp_pkg::*;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [2:0]             tap_q;
  logic                   line_q;
  logic                   line_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
    end else begin
      sync_q[0] <= rxd;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign raw = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_q  <= '1;
      line_q <= 1'b1;
    end else begin
      tap_q  <= {tap_q[1:0], raw};
      line_q <= line_d;
    end
  end

  assign line_d = filt ? maj3(tap_q) : raw;
  assign line   = line_q;
  // edge is seen as the low level is loaded, so slot 0 holds the first low sample
  assign fall   = line_q & ~line_d;
endmodule

// File: rtl/winsamp_timer.sv
module winsamp_timer #(
  parameter int CNT_W     = 16,
  parameter int SLOT_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 zero,
  input  logic [CNT_W-1:0]     rate,
  output logic [CNT_W-1:0]     cnt,
  output logic [SLOT_BITS-1:0] slot,
  output logic                 bit_end,
  output logic                 bclk
);
  localparam int NSLOT = 1 << SLOT_BITS;
  localparam int ACC_W = CNT_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;
  logic [CNT_W-1:0] rate_m1;

  assign rate_m1 = rate - CNT_W'(1);
  assign bit_end = run && (cnt >= rate_m1);
  assign acc_sum = acc_q + ACC_W'(NSLOT);
  assign bclk    = ~slot[SLOT_BITS-1];

  always_ff @(posedge clk) begin
    if (rst || !run || zero || bit_end) begin
      cnt   <= '0;
      acc_q <= '0;
      slot  <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
      if (acc_sum >= {1'b0, rate}) begin
        acc_q <= acc_sum - {1'b0, rate};
        if (slot != '1) slot <= slot + SLOT_BITS'(1);
      end else begin
        acc_q <= acc_sum;
      end
    end
  end
endmodule

// File: rtl/winsamp_core.sv
module winsamp_core #(
  parameter int CNT_W     = 16,
  parameter int HOLD_W    = 16,
  parameter int NB_W      = 4,
  parameter int SLOT_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 line,
  input  logic                 fall,
  input  logic [SLOT_BITS-1:0] slot,
  input  logic                 bit_end,
  input  logic [NB_W-1:0]      nbits,
  input  logic [SLOT_BITS-1:0] first,
  input  logic [SLOT_BITS-1:0] last,
  input  logic                 clr_flags,
  output logic                 start,
  output logic [HOLD_W-1:0]    hold,
  output logic                 ready,
  output logic                 ovf,
  output logic                 splerr
);
  import winsamp_pkg::*;
  rx_st_e             state;
  logic [NB_W-1:0]    idx_q;
  logic [CNT_W-1:0]   ones_q, zeros_q, ones_n, zeros_n;
  logic [HOLD_W-1:0]  shreg_q, shifted;
  logic               inwin, bit_v, bit_bad, last_bit;

  assign start    = (state == ST_HUNT) && run && fall;
  assign inwin    = (slot >= first) && (slot <= last);
  assign ones_n   = ones_q  + {{(CNT_W-1){1'b0}}, inwin &  line};
  assign zeros_n  = zeros_q + {{(CNT_W-1){1'b0}}, inwin & ~line};
  assign bit_v    = ones_n > zeros_n;
  assign bit_bad  = (ones_n == '0) == (zeros_n == '0);
  assign shifted  = {bit_v, shreg_q[HOLD_W-1:1]};
  assign last_bit = (idx_q == nbits - NB_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HUNT;
      idx_q   <= '0;
      ones_q  <= '0;
      zeros_q <= '0;
      shreg_q <= '0;
      hold    <= '0;
      ready   <= 1'b0;
      ovf     <= 1'b0;
      splerr  <= 1'b0;
    end else begin
      if (clr_flags) begin
        ready  <= 1'b0;
        ovf    <= 1'b0;
        splerr <= 1'b0;
      end
      case (state)
        ST_HUNT: begin
          if (start) begin
            state   <= ST_RECV;
            idx_q   <= '0;
            ones_q  <= '0;
            zeros_q <= '0;
            shreg_q <= '0;
          end
        end
        default: begin
          if (!run) begin
            state <= ST_HUNT;
          end else if (bit_end) begin
            ones_q  <= '0;
            zeros_q <= '0;
            shreg_q <= shifted;
            if (bit_bad) splerr <= 1'b1;
            if (last_bit) begin
              hold  <= shifted;
              ready <= 1'b1;
              if (ready) ovf <= 1'b1;
              state <= ST_HUNT;
            end else begin
              idx_q <= idx_q + NB_W'(1);
            end
          end else begin
            ones_q  <= ones_n;
            zeros_q <= zeros_n;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/winsamp_rx.sv
module winsamp_rx #(
  parameter int CNT_W       = 16,
  parameter int HOLD_W      = 16,
  parameter int NB_W        = 4,
  parameter int SLOT_BITS   = 4,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              rxd_in,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [CNT_W+NB_W+2*SLOT_BITS+1:0] wr_data,
  output logic [HOLD_W-1:0]                 rx_hold,
  output logic                              rx_ready,
  output logic                              rx_ovf,
  output logic                              rx_splerr,
  output logic [CNT_W-1:0]                  st_cnt,
  output logic                              st_bclk,
  output logic                              st_raw
);
  logic [CNT_W-1:0]     cfg_rate;
  logic                 cfg_en, cfg_filt;
  logic [NB_W-1:0]      cfg_nbits;
  logic [SLOT_BITS-1:0] cfg_first, cfg_last, slot;
  logic                 clr_flags, clr_cnt, run, line, fall, start, bit_end;

  assign run = cfg_en && (cfg_rate != '0);

  winsamp_regs #(.CNT_W(CNT_W), .NB_W(NB_W), .SLOT_BITS(SLOT_BITS), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rate(cfg_rate), .en(cfg_en), .filt(cfg_filt), .nbits(cfg_nbits),
    .first(cfg_first), .last(cfg_last), .clr_flags(clr_flags), .clr_cnt(clr_cnt)
  );

  winsamp_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
    .clk(clk), .rst(rst), .rxd(rxd_in), .filt(cfg_filt),
    .raw(st_raw), .line(line), .fall(fall)
  );

  winsamp_timer #(.CNT_W(CNT_W), .SLOT_BITS(SLOT_BITS)) timer_i (
    .clk(clk), .rst(rst), .run(run), .zero(clr_cnt | start), .rate(cfg_rate),
    .cnt(st_cnt), .slot(slot), .bit_end(bit_end), .bclk(st_bclk)
  );

  winsamp_core #(.CNT_W(CNT_W), .HOLD_W(HOLD_W), .NB_W(NB_W), .SLOT_BITS(SLOT_BITS)) core_i (
    .clk(clk), .rst(rst), .run(run), .line(line), .fall(fall), .slot(slot),
    .bit_end(bit_end), .nbits(cfg_nbits), .first(cfg_first), .last(cfg_last),
    .clr_flags(clr_flags), .start(start), .hold(rx_hold), .ready(rx_ready),
    .ovf(rx_ovf), .splerr(rx_splerr)
  );
endmodule

// File: rtl/winsamp_rx_chk.sv
module winsamp_rx_chk #(
  parameter int CNT_W  = 16,
  parameter int HOLD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              bit_end,
  input logic              clr_flags,
  input logic              clr_cnt,
  input logic              ready,
  input logic              ovf,
  input logic              err,
  input logic [HOLD_W-1:0] hold,
  input logic [CNT_W-1:0]  cnt
);
  // R5
  ready_at_bit_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(bit_end));
  // R8
  ovf_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(ready));
  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_flags && !bit_end) |=> (!ready && !ovf && !err));
  // R3
  cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr_cnt |=> (cnt == '0));
  // R2
  idle_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
  // R4
  hold_update_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(hold) |-> ready);
  // R6
  err_at_bit_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(bit_end));
endmodule

bind winsamp_rx winsamp_rx_chk #(.CNT_W(CNT_W), .HOLD_W(HOLD_W)) chk_i (
  .clk(clk), .rst(rst), .run(run), .bit_end(bit_end), .clr_flags(clr_flags),
  .clr_cnt(clr_cnt), .ready(rx_ready), .ovf(rx_ovf), .err(rx_splerr),
  .hold(rx_hold), .cnt(st_cnt)
);

// File: tb/winsamp_rx_tb.sv
module winsamp_rx_tb_top;
  localparam int CLK_NS = 10;
  localparam int RATE   = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rxd = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [29:0] wr_data = '0;
  logic [15:0] rx_hold, st_cnt;
  logic        rx_ready, rx_ovf, rx_splerr, st_bclk, st_raw;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  winsamp_rx dut_i (
    .clk(clk), .rst(rst), .rxd_in(rxd), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rx_hold(rx_hold), .rx_ready(rx_ready), .rx_ovf(rx_ovf),
    .rx_splerr(rx_splerr), .st_cnt(st_cnt), .st_bclk(st_bclk), .st_raw(st_raw)
  );

  // nbits[28:25] pattern[24:9] first[8:5] last[4:1] filter[0]
  localparam logic [28:0] VECS [6] = '{
    {4'd11, 16'h056A, 4'd5,  4'd10, 1'b0},
    {4'd8,  16'h00B4, 4'd2,  4'd13, 1'b1},
    {4'd0,  16'hA55A, 4'd0,  4'd15, 1'b0},
    {4'd5,  16'h0016, 4'd5,  4'd10, 1'b0},
    {4'd12, 16'h0E4C, 4'd7,  4'd8,  1'b1},
    {4'd2,  16'h0002, 4'd3,  4'd12, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [29:0] mk_cfg(input int rate, input bit en, input bit filt,
                                         input int nb, input int fs, input int ls);
    return {ls[3:0], fs[3:0], nb[3:0], filt, en, rate[15:0]};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [29:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input int n, input logic [15:0] pat, input int gbit, input int goff,
                      input bit early);
    for (int i = 0; i < n; i++) begin
      for (int c = 0; c < RATE; c++) begin
        @(negedge clk);
        rxd = pat[i] ^ ((i == gbit) && (c == goff));
        if (early && i == n-1 && c == RATE/2) chk("R5 ready early", 32'(rx_ready), 0);
      end
    end
    @(negedge clk);
    rxd = 1'b1;
    repeat (RATE/2) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_hold(input int nb, input logic [15:0] pat);
    int n;
    logic [31:0] m;
    n = (nb == 0) ? 16 : nb;
    m = (32'(1) << n) - 1;
    return 16'((32'(pat) & m) << (16 - n));
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 hold", 32'(rx_hold), 0);
    chk("R1 ready", 32'(rx_ready), 0);
    chk("R1 ovf", 32'(rx_ovf), 0);
    chk("R1 err", 32'(rx_splerr), 0);
    chk("R1 cnt", 32'(st_cnt), 0);

    // R11 raw line readback while disabled
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 raw low", 32'(st_raw), 0);
    rxd = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 raw high", 32'(st_raw), 1);

    // R2 inactive: rate zero, then disabled
    wr(2'd0, mk_cfg(0, 1, 0, 11, 5, 10));
    send(11, 16'h056A, -1, -1, 0);
    chk("R2 rate0 ready", 32'(rx_ready), 0);
    chk("R2 rate0 cnt", 32'(st_cnt), 0);
    wr(2'd0, mk_cfg(RATE, 0, 0, 11, 5, 10));
    send(11, 16'h056A, -1, -1, 0);
    chk("R2 disabled ready", 32'(rx_ready), 0);
    chk("R2 disabled cnt", 32'(st_cnt), 0);

    // R3 counter, clear and bit clock
    wr(2'd0, mk_cfg(RATE, 1, 0, 11, 5, 10));
    repeat (40) @(negedge clk);
    wr(2'd2, '0);
    chk("R3 cnt cleared", 32'(st_cnt), 0);
    repeat (5) @(negedge clk);
    chk("R3 cnt 5", 32'(st_cnt), 5);
    chk("R3 bclk high", 32'(st_bclk), 1);
    repeat (15) @(negedge clk);
    chk("R3 cnt 20", 32'(st_cnt), 20);
    chk("R3 bclk low", 32'(st_bclk), 0);
    repeat (12) @(negedge clk);
    chk("R3 cnt wrap", 32'(st_cnt), 0);

    // R4 R5 R11 vector table
    foreach (VECS[k]) begin
      logic [3:0]  nb;
      logic [15:0] pat;
      int          nbits;
      nb    = VECS[k][28:25];
      pat   = VECS[k][24:9];
      nbits = (nb == 0) ? 16 : int'(nb);
      wr(2'd0, mk_cfg(RATE, 1, VECS[k][0], int'(nb), int'(VECS[k][8:5]), int'(VECS[k][4:1])));
      wr(2'd1, '0);
      send(nbits, pat, -1, -1, 1);
      chk($sformatf("R4 vec%0d hold", k), 32'(rx_hold), 32'(exp_hold(int'(nb), pat)));
      chk($sformatf("R5 vec%0d ready", k), 32'(rx_ready), 1);
      chk($sformatf("R8 vec%0d ovf", k), 32'(rx_ovf), 0);
      chk($sformatf("R6 vec%0d err", k), 32'(rx_splerr), 0);
    end

    // R6 glitch inside window, filter off
    wr(2'd0, mk_cfg(RATE, 1, 0, 11, 4, 11));
    wr(2'd1, '0);
    send(11, 16'h056A, 3, 16, 0);
    chk("R6 err set", 32'(rx_splerr), 1);
    chk("R6 majority hold", 32'(rx_hold), 32'h0000AD40);

    // R10 same glitch, filter on
    wr(2'd0, mk_cfg(RATE, 1, 1, 11, 4, 11));
    wr(2'd1, '0);
    send(11, 16'h056A, 3, 16, 0);
    chk("R10 err clear", 32'(rx_splerr), 0);
    chk("R10 hold", 32'(rx_hold), 32'h0000AD40);

    // R7 glitch outside window
    wr(2'd0, mk_cfg(RATE, 1, 0, 11, 6, 9));
    wr(2'd1, '0);
    send(11, 16'h056A, 3, 2, 0);
    chk("R7 err clear", 32'(rx_splerr), 0);
    chk("R7 hold", 32'(rx_hold), 32'h0000AD40);

    // R8 overflow, R9 clear
    wr(2'd0, mk_cfg(RATE, 1, 0, 8, 4, 11));
    wr(2'd1, '0);
    send(8, 16'h00B4, -1, -1, 0);
    chk("R8 first ovf", 32'(rx_ovf), 0);
    send(8, 16'h0056, -1, -1, 0);
    chk("R8 ovf set", 32'(rx_ovf), 1);
    chk("R8 hold replaced", 32'(rx_hold), 32'h00005600);
    wr(2'd1, '0);
    chk("R9 ready", 32'(rx_ready), 0);
    chk("R9 ovf", 32'(rx_ovf), 0);
    chk("R9 err", 32'(rx_splerr), 0);
    chk("R9 hold kept", 32'(rx_hold), 32'h00005600);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule